// File: doc/BRIEF.md
# Power-Fail Miscellaneous Control Registers

This block is a small set of memory-mapped control registers on a simple synchronous bus. It holds several byte-wide registers: configuration, two auxiliary registers, diagnostics and modem control. It also holds a 32-bit system-control register. Writes to certain addresses produce one-cycle request pulses: a shutdown request, a reset request and a CPU halt request. The rest of the system acts on those pulses.

The second auxiliary register mixes two kinds of bits. Two of its bits are write-only commands (power off and interrupt clear). One bit is a power-fail status owned by the hardware. That status bit is driven by a power-failing input level and can only be cleared by the clear command. The interrupt output is a level. It is high while the status bit is set and the enable bit in the configuration register is set.

Registers are selected by masking the address with a select mask and comparing the result with fixed offsets. Address bits outside the mask are ignored, except for the system-control sub-offset.

Top module: `pwrfail_misc_regs`

## Requirements
- R1: The address is ANDed with 0x0FFF0000 and the result selects the register. The offsets are config 0x01800000, aux1 0x01900000, diag 0x01A00000 and modem control 0x01B00000. A write to one of these stores `bus_wdata[7:0]`, and a read returns that byte zero-extended.
- R2: A write to aux2 (0x01910000) stores only the power-off command from `bus_wdata[0]`. An aux2 read shows power-off at bit 0 and power-fail status at bit 5, with all other bits zero. Bit 1 always reads 0, and written bits 7..2 have no effect.
- R3: An aux2 write with `bus_wdata[1]` set clears the power-fail status (bit 5).
- R4: An aux2 write with `bus_wdata[0]` set raises `shutdown_req` for exactly one cycle, in the cycle after the write.
- R5: `irq` is high exactly when aux2 bit 5 and config bit 3 are both set. Clearing config bit 3 lowers `irq` but leaves the status bit unchanged.
- R6: A cycle in which `pwr_failing` differs from its value in the previous cycle is a power event. On a power event, the status bit becomes `pwr_failing` AND the config bit 3 held before that cycle. Without a power event the status bit holds. An aux2 clear command in the same cycle takes priority and leaves the status bit at 0.
- R7: Any write to 0x0A000000 raises `halt_req` for exactly one cycle, in the cycle after the write. A read of that address returns 0.
- R8: At 0x01F00000 with `bus_addr[15:0]` equal to 0, a write with `bus_wdata[0]` set does two things. It makes the system-control register read 0x00000002 and raises `reset_req` for one cycle. Other writes in that region do not change the register.
- R9: A read returns 0 in three cases: when `bus_rd` is low, when the address matches no offset, and for system-control sub-offsets other than 0.
- R10: Reset clears all byte registers, the status bit and the pulses. The system-control reset-status flag is the exception: it starts at 0 and survives a later reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data (byte registers use bits 7..0) |
| bus_rdata | output | 32 | Combinational read data |
| pwr_failing | input | 1 | Power-failing level |
| irq | output | 1 | Power-fail interrupt level |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reset_req | output | 1 | One-cycle reset request |
| halt_req | output | 1 | One-cycle CPU halt request |

## Verification
Two things can land in the same cycle: a power event from `pwr_failing` and a bus write to aux2 or config. Both contend for the power-fail status bit. The bench provokes this with directed cases: a rising `pwr_failing` edge coincident with an aux2 clear, and another coincident with a config write that changes the enable. It also lets random toggles of `pwr_failing` overlap random writes. In each such cycle the bench model applies the clear-wins and old-enable rules, and the following cycle's aux2 read and `irq` are compared with the model.

// File: rtl/pwrfail_misc_regs.sv
module pwrfail_misc_regs #(
  parameter int          AW         = 32,
  parameter int          DW         = 32,
  parameter int          RW         = 8,
  parameter int          SUB_W      = 16,
  parameter logic [31:0] SEL_MASK   = 32'h0FFF_0000,
  parameter logic [31:0] CFG_OFS    = 32'h0180_0000,
  parameter logic [31:0] AUX1_OFS   = 32'h0190_0000,
  parameter logic [31:0] AUX2_OFS   = 32'h0191_0000,
  parameter logic [31:0] DIAG_OFS   = 32'h01A0_0000,
  parameter logic [31:0] MDM_OFS    = 32'h01B0_0000,
  parameter logic [31:0] PWR_OFS    = 32'h0A00_0000,
  parameter logic [31:0] SYS_OFS    = 32'h01F0_0000,
  parameter int          EN_BIT     = 3,
  parameter int          OFF_BIT    = 0,
  parameter int          CLR_BIT    = 1,
  parameter int          FAIL_BIT   = 5,
  parameter int          SRST_BIT   = 0,
  parameter int          SFLAG_BIT  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          pwr_failing,
  output logic          irq,
  output logic          shutdown_req,
  output logic          reset_req,
  output logic          halt_req
);

  logic [AW-1:0] sel;
  logic hit_cfg, hit_aux1, hit_aux2, hit_diag, hit_mdm, hit_pwr, hit_sys, hit_sys0;
  logic wr_aux2, wr_sys_rst, pf_evt, fail_d;

  logic [RW-1:0] cfg_q, aux1_q, diag_q, mdm_q;
  logic          off_q, fail_q, pin_q;
  logic          sys_flag_q = 1'b0;
  logic [RW-1:0] aux2_v;
  logic [DW-1:0] sys_v;

  assign sel      = bus_addr & SEL_MASK[AW-1:0];
  assign hit_cfg  = sel == CFG_OFS[AW-1:0];
  assign hit_aux1 = sel == AUX1_OFS[AW-1:0];
  assign hit_aux2 = sel == AUX2_OFS[AW-1:0];
  assign hit_diag = sel == DIAG_OFS[AW-1:0];
  assign hit_mdm  = sel == MDM_OFS[AW-1:0];
  assign hit_pwr  = sel == PWR_OFS[AW-1:0];
  assign hit_sys  = sel == SYS_OFS[AW-1:0];
  assign hit_sys0 = hit_sys && (bus_addr[SUB_W-1:0] == '0);

  assign wr_aux2    = bus_wr && hit_aux2;
  assign wr_sys_rst = bus_wr && hit_sys0 && bus_wdata[SRST_BIT];
  assign pf_evt     = pwr_failing != pin_q;

  always_comb begin
    fail_d = fail_q;
    if (pf_evt) fail_d = pwr_failing && cfg_q[EN_BIT];
    if (wr_aux2 && bus_wdata[CLR_BIT]) fail_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q        <= '0;
      aux1_q       <= '0;
      diag_q       <= '0;
      mdm_q        <= '0;
      off_q        <= 1'b0;
      fail_q       <= 1'b0;
      pin_q        <= 1'b0;
      shutdown_req <= 1'b0;
      reset_req    <= 1'b0;
      halt_req     <= 1'b0;
    end else begin
      if (bus_wr && hit_cfg)  cfg_q  <= bus_wdata[RW-1:0];
      if (bus_wr && hit_aux1) aux1_q <= bus_wdata[RW-1:0];
      if (bus_wr && hit_diag) diag_q <= bus_wdata[RW-1:0];
      if (bus_wr && hit_mdm)  mdm_q  <= bus_wdata[RW-1:0];
      if (wr_aux2)            off_q  <= bus_wdata[OFF_BIT];
      fail_q       <= fail_d;
      pin_q        <= pwr_failing;
      shutdown_req <= wr_aux2 && bus_wdata[OFF_BIT];
      reset_req    <= wr_sys_rst;
      halt_req     <= bus_wr && hit_pwr;
    end
  end

  always_ff @(posedge clk)
    if (wr_sys_rst) sys_flag_q <= 1'b1;

  assign irq = fail_q && cfg_q[EN_BIT];

  always_comb begin
    aux2_v           = '0;
    aux2_v[OFF_BIT]  = off_q;
    aux2_v[FAIL_BIT] = fail_q;
    sys_v            = '0;
    sys_v[SFLAG_BIT] = sys_flag_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_cfg)       bus_rdata = DW'(cfg_q);
      else if (hit_aux1) bus_rdata = DW'(aux1_q);
      else if (hit_aux2) bus_rdata = DW'(aux2_v);
      else if (hit_diag) bus_rdata = DW'(diag_q);
      else if (hit_mdm)  bus_rdata = DW'(mdm_q);
      else if (hit_sys0) bus_rdata = sys_v;
    end
  end

  a_r3_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_aux2 && bus_wdata[CLR_BIT]) |=> !irq);

  a_r4_shutdown_cause: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(bus_wr && hit_aux2 && bus_wdata[OFF_BIT]));

  a_r4_shutdown_single: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> !shutdown_req || $past(bus_wr && hit_aux2 && bus_wdata[OFF_BIT]));

  a_r7_halt_cause: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> $past(bus_wr && hit_pwr));

  a_r7_pwr_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && hit_pwr) |-> bus_rdata == '0);

  a_r8_reset_flag: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> sys_flag_q);

  a_r5_irq_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_cfg && !bus_wdata[EN_BIT]) |=> !irq);

  a_r9_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);

endmodule

// File: tb/tb_pwrfail_misc_regs.sv
module tb_pwrfail_misc_regs;
  localparam logic [31:0] A_CFG = 32'h0180_0000, A_AUX1 = 32'h0190_0000,
    A_AUX2 = 32'h0191_0000, A_DIAG = 32'h01A0_0000, A_MDM = 32'h01B0_0000,
    A_PWR = 32'h0A00_0000, A_SYS = 32'h01F0_0000, A_NONE = 32'h01C0_0000;

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0, pwr_failing = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic irq, shutdown_req, reset_req, halt_req;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_cfg, m_aux1, m_diag, m_mdm;
  logic m_off, m_pf, m_pin, m_sys = 0;

  pwrfail_misc_regs dut (.clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata,
    .bus_rdata, .pwr_failing, .irq, .shutdown_req, .reset_req, .halt_req);

  always #4 clk = ~clk;

  function automatic int dec(input logic [31:0] a);
    logic [31:0] s = a & 32'h0FFF_0000;
    if (s == A_CFG) return 1;
    if (s == A_AUX1) return 2;
    if (s == A_AUX2) return 3;
    if (s == A_DIAG) return 4;
    if (s == A_MDM) return 5;
    if (s == A_PWR) return 6;
    if (s == A_SYS && a[15:0] == 0) return 7;
    return 0;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [31:0] a, input logic r);
    if (!r) return 0;
    case (dec(a))
      1: return {24'h0, m_cfg};
      2: return {24'h0, m_aux1};
      3: return {26'h0, m_pf, 4'h0, m_off};
      4: return {24'h0, m_diag};
      5: return {24'h0, m_mdm};
      7: return {30'h0, m_sys, 1'b0};
      default: return 0;
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; bus_wr = 0; bus_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_cfg = 0; m_aux1 = 0; m_diag = 0; m_mdm = 0; m_off = 0; m_pf = 0; m_pin = 0;
  endtask

  task automatic step(input logic [31:0] a, input logic w, input logic r,
                      input logic [31:0] d, input logic pf, input string req);
    int k;
    logic npf, esd, ers, eh;
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d; pwr_failing = pf;
    #1 chk(bus_rdata, exp_rd(a, r), req);
    k = dec(a);
    npf = m_pf;
    if (pf != m_pin) npf = pf & m_cfg[3];
    if (w && k == 3 && d[1]) npf = 0;
    esd = w && k == 3 && d[0];
    ers = w && k == 7 && d[0];
    eh  = w && k == 6;
    if (w) case (k)
      1: m_cfg = d[7:0];
      2: m_aux1 = d[7:0];
      3: m_off = d[0];
      4: m_diag = d[7:0];
      5: m_mdm = d[7:0];
      7: if (d[0]) m_sys = 1;
      default: ;
    endcase
    m_pf = npf; m_pin = pf;
    @(posedge clk); #1;
    chk({31'h0, irq}, {31'h0, m_pf & m_cfg[3]}, {req, " R5 irq"});
    chk({29'h0, shutdown_req, reset_req, halt_req}, {29'h0, esd, ers, eh}, {req, " R4/R7/R8 pulses"});
    bus_wr = 0; bus_rd = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] alist [8];
    logic p;
    alist = '{A_CFG, A_AUX1, A_AUX2, A_DIAG, A_MDM, A_PWR, A_SYS, A_NONE};
    void'($urandom(32'd1234));
    do_reset();
    foreach (alist[i]) step(alist[i], 0, 1, 0, 0, "R10 reset state");
    // R1 byte registers with ignored high bits
    step(32'hF180_1234, 1, 0, 32'hABCD_EF5A, 0, "R1");
    step(A_CFG, 0, 1, 0, 0, "R1 cfg readback");
    step(A_MDM, 1, 0, 32'h0000_0133, 0, "R1");
    step(A_MDM | 32'h3, 0, 1, 0, 0, "R1 modem readback");
    // R5/R6 power fail with enable
    step(A_CFG, 1, 0, 32'h08, 0, "R5");
    step(A_AUX2, 0, 1, 0, 1, "R6 rising event");
    step(A_AUX2, 0, 1, 0, 1, "R6 status set");
    // R2 aux2 write keeps status, stores off, ignores high bits
    step(A_AUX2, 1, 0, 32'hFD, 1, "R2 R4 off write");
    step(A_AUX2, 0, 1, 0, 1, "R2 readback 0x21");
    step(A_CFG, 1, 0, 32'h00, 1, "R5 disable");
    step(A_AUX2, 0, 1, 0, 1, "R5 status kept");
    step(A_CFG, 1, 0, 32'h08, 1, "R5 reenable");
    // R3 clear
    step(A_AUX2, 1, 0, 32'h02, 1, "R3 clear");
    step(A_AUX2, 0, 1, 0, 1, "R3 readback");
    // R6 clear wins over coincident event
    step(A_AUX2, 0, 0, 0, 0, "R6 fall");
    step(A_AUX2, 1, 0, 32'h02, 1, "R6 clear vs rise");
    step(A_AUX2, 0, 1, 0, 1, "R6 clear wins");
    // R6 event uses old enable when config write coincides
    step(A_CFG, 1, 0, 32'h00, 0, "R6 fall");
    step(A_CFG, 1, 0, 32'h08, 1, "R6 old enable");
    step(A_AUX2, 0, 1, 0, 1, "R6 not set");
    // R7 halt
    step(A_PWR | 32'h55, 1, 0, 32'h0, 1, "R7 halt");
    step(A_PWR, 0, 1, 0, 1, "R7 read zero");
    // R9 unmapped / sub-offset / rd low
    step(A_NONE, 0, 1, 0, 1, "R9 unmapped");
    step(A_SYS | 32'h4, 1, 0, 32'h1, 1, "R8 other offset");
    step(A_SYS | 32'h4, 0, 1, 0, 1, "R9 sys offset");
    step(A_CFG, 0, 0, 0, 1, "R9 rd low");
    // R8 system control
    step(A_SYS, 1, 0, 32'h0, 1, "R8 no bit0");
    step(A_SYS, 0, 1, 0, 1, "R8 still zero");
    step(A_SYS, 1, 0, 32'hFFFF_FFFF, 1, "R8 reset write");
    step(A_SYS, 0, 1, 0, 1, "R8 readback");
    // R10 flag survives reset
    do_reset();
    step(A_SYS, 0, 1, 0, 0, "R10 flag kept");
    step(A_CFG, 0, 1, 0, 0, "R10 cfg cleared");
    // random
    p = 0;
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a;
      a = alist[$urandom_range(0, 7)];
      a = a | {$urandom_range(0, 15), 12'h0, 16'h0};
      if ($urandom_range(0, 1)) a[15:0] = 16'($urandom);
      if ($urandom_range(0, 7) == 0) p = ~p;
      step(a, $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
           $urandom, p, "random R1-model");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule